// File: doc/BRIEF.md
# Interrupt Mask and Entry Controller

This block owns the two interrupt mask bits of a processor core: one for the normal interrupt and one for the fast interrupt. Each cycle it samples two active-low request lines. It decides whether either interrupt may be taken and gives the fast one priority. On entry it sets the mask bits that the entered mode requires. It issues a one-cycle entry strobe and tracks whether the core is inside a fast handler. Software writes to the mask bits are applied through a write port, except in a cycle where an entry happens.

A strap input selects non-maskable fast interrupt operation. With the strap high, software can only clear the fast mask. The fast mask then becomes one again only through fast-interrupt entry or reset. The strap is shown in a read-only bit of the system control word. That word also carries a latency-mode bit that always reads one. The block also computes the fast handler's return address, which is the saved link value minus four.

Top module: `intr_entry_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, maskI and maskF read 1, fiqActive reads 0, and takeIrq and takeFiq read 0.
- R2: irqLineN and fiqLineN are active low and level sensitive. A line is registered once. An entry is decided from the registered level in the next cycle, and the matching take strobe is high in the cycle after that. A request that goes away before it is sampled leaves no trace.
- R3: When both registered requests are eligible, only takeFiq pulses. takeIrq and takeFiq are never high together.
- R4: A normal request is eligible only when maskI is 0 and fiqActive is 0. On entry, takeIrq pulses for one cycle and maskI becomes 1 in the same cycle, while maskF keeps its value.
- R5: A fast request is eligible only when maskF is 0 and fiqActive is 0. On entry, takeFiq pulses for one cycle, and maskI, maskF and fiqActive all become 1 in the same cycle.
- R6: While fiqActive is 1, no entry is taken, even with both masks cleared. fiqRet clears fiqActive at the next edge, and when fiqActive is already 0 it has no effect.
- R7: With nmfiStrap at 0, a cycle with swWrEn high loads maskI from swWrI and maskF from swWrF.
- R8: With nmfiStrap at 1, a software write loads maskI from swWrI. A write with swWrF at 0 clears maskF, and a write with swWrF at 1 leaves maskF unchanged.
- R9: In a cycle where an entry is decided, the software write is discarded.
- R10: ctrlReg has bit 21 at 1 and bit 27 equal to nmfiStrap, and every other bit is 0.
- R11: retAddr equals lrFiq minus 4, modulo 2^AW, for any lrFiq value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqLineN | input | 1 | Normal interrupt request, active low |
| fiqLineN | input | 1 | Fast interrupt request, active low |
| nmfiStrap | input | 1 | High selects non-maskable fast interrupt operation |
| swWrEn | input | 1 | Software write strobe for the mask bits |
| swWrI | input | 1 | Value written to the normal mask |
| swWrF | input | 1 | Value written to the fast mask |
| fiqRet | input | 1 | Fast handler return, leaves fast-handler mode |
| lrFiq | input | AW | Saved link value of the fast mode |
| takeIrq | output | 1 | One-cycle normal interrupt entry strobe |
| takeFiq | output | 1 | One-cycle fast interrupt entry strobe |
| maskI | output | 1 | Normal interrupt mask |
| maskF | output | 1 | Fast interrupt mask |
| fiqActive | output | 1 | Core is inside a fast handler |
| retAddr | output | AW | Fast handler return address |
| ctrlReg | output | 32 | Read-only system control word |

## Verification
The assertions assume that nmfiStrap changes only while reset is asserted. The non-maskable rule for maskF is judged against the current strap value, so a strap change during operation could trip it. The stimulus changes the strap only inside a reset pulse and otherwise drives random request levels, software writes, handler returns and link values. Requests are held for varying lengths, so that removal before sampling, simultaneous requests and writes that collide with an entry all occur in both strap settings.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;
  // Strobes from the control path into the mask datapath
  typedef struct packed {
    logic enterIrq;
    logic enterFiq;
    logic swWrite;
  } ctlStrobeT;
endpackage

// File: rtl/intr_entry_ctl.sv
module intr_entry_ctl
  import intr_entry_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       irqLineN,
  input  logic       fiqLineN,
  input  logic       swWrEn,
  input  logic       maskI,
  input  logic       maskF,
  input  logic       fiqActive,
  output ctlStrobeT  strobe,
  output logic       takeIrq,
  output logic       takeFiq
);
  logic irqReq, fiqReq;
  logic wantIrq, wantFiq;

  // Level sample of the active-low lines; nothing is held once a line releases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq <= 1'b0;
      fiqReq <= 1'b0;
    end else begin
      irqReq <= ~irqLineN;
      fiqReq <= ~fiqLineN;
    end
  end

  // Fast request wins; nothing is taken inside a fast handler
  always_comb begin
    wantFiq = fiqReq & ~maskF & ~fiqActive;
    wantIrq = irqReq & ~maskI & ~fiqActive & ~wantFiq;
    strobe.enterFiq = wantFiq;
    strobe.enterIrq = wantIrq;
    strobe.swWrite  = swWrEn & ~wantFiq & ~wantIrq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      takeIrq <= 1'b0;
      takeFiq <= 1'b0;
    end else begin
      takeIrq <= wantIrq;
      takeFiq <= wantFiq;
    end
  end
endmodule

// File: rtl/intr_entry_dp.sv
module intr_entry_dp
  import intr_entry_pkg::*;
#(
  parameter int AW       = 32,
  parameter int CW       = 32,
  parameter int LIL_BIT  = 21,
  parameter int NMFI_BIT = 27,
  parameter int RET_OFS  = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobeT     strobe,
  input  logic          swWrI,
  input  logic          swWrF,
  input  logic          nmfiStrap,
  input  logic          fiqRet,
  input  logic [AW-1:0] lrFiq,
  output logic          maskI,
  output logic          maskF,
  output logic          fiqActive,
  output logic [AW-1:0] retAddr,
  output logic [CW-1:0] ctrlReg
);
  localparam logic [AW-1:0] RetOfs = AW'(RET_OFS);

  logic nextF;

  // Software view of the fast mask: with the strap set, ones cannot be written
  always_comb begin
    if (nmfiStrap) nextF = maskF & swWrF;
    else           nextF = swWrF;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskI     <= 1'b1;
      maskF     <= 1'b1;
      fiqActive <= 1'b0;
    end else begin
      if (strobe.enterFiq) begin
        maskI     <= 1'b1;
        maskF     <= 1'b1;
        fiqActive <= 1'b1;
      end else begin
        if (strobe.enterIrq) begin
          maskI <= 1'b1;
        end else if (strobe.swWrite) begin
          maskI <= swWrI;
          maskF <= nextF;
        end
        if (fiqRet) fiqActive <= 1'b0;
      end
    end
  end

  assign retAddr = lrFiq - RetOfs;

  always_comb begin
    ctrlReg           = '0;
    ctrlReg[LIL_BIT]  = 1'b1;
    ctrlReg[NMFI_BIT] = nmfiStrap;
  end
endmodule

// File: rtl/intr_entry_ctrl.sv
module intr_entry_ctrl
  import intr_entry_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          irqLineN,
  input  logic          fiqLineN,
  input  logic          nmfiStrap,
  input  logic          swWrEn,
  input  logic          swWrI,
  input  logic          swWrF,
  input  logic          fiqRet,
  input  logic [AW-1:0] lrFiq,
  output logic          takeIrq,
  output logic          takeFiq,
  output logic          maskI,
  output logic          maskF,
  output logic          fiqActive,
  output logic [AW-1:0] retAddr,
  output logic [31:0]   ctrlReg
);
  ctlStrobeT strobe;

  intr_entry_ctl ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .irqLineN (irqLineN),
    .fiqLineN (fiqLineN),
    .swWrEn   (swWrEn),
    .maskI    (maskI),
    .maskF    (maskF),
    .fiqActive(fiqActive),
    .strobe   (strobe),
    .takeIrq  (takeIrq),
    .takeFiq  (takeFiq)
  );

  intr_entry_dp #(.AW(AW), .CW(32)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .swWrI    (swWrI),
    .swWrF    (swWrF),
    .nmfiStrap(nmfiStrap),
    .fiqRet   (fiqRet),
    .lrFiq    (lrFiq),
    .maskI    (maskI),
    .maskF    (maskF),
    .fiqActive(fiqActive),
    .retAddr  (retAddr),
    .ctrlReg  (ctrlReg)
  );
endmodule

// File: rtl/intr_entry_chk.sv
module intr_entry_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          irqLineN,
  input logic          fiqLineN,
  input logic          nmfiStrap,
  input logic          swWrEn,
  input logic          swWrI,
  input logic          swWrF,
  input logic          fiqRet,
  input logic [AW-1:0] lrFiq,
  input logic          takeIrq,
  input logic          takeFiq,
  input logic          maskI,
  input logic          maskF,
  input logic          fiqActive,
  input logic [AW-1:0] retAddr,
  input logic [31:0]   ctrlReg
);
  AST_ONE_ENTRY: assert property (@(posedge clk) disable iff (!rstN) $onehot0({takeIrq, takeFiq})); // R3
  AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (!rstN) takeIrq |-> (maskI && $stable(maskF))); // R4
  AST_FIQ_ENTRY: assert property (@(posedge clk) disable iff (!rstN) takeFiq |-> (maskI && maskF && fiqActive)); // R5
  AST_FIQ_HOLDS: assert property (@(posedge clk) disable iff (!rstN) $past(fiqActive) |-> !(takeIrq || takeFiq)); // R6
  AST_NMFI_SET: assert property (@(posedge clk) disable iff (!rstN) (nmfiStrap && $rose(maskF)) |-> takeFiq); // R8
  AST_CTRL_BITS: assert property (@(posedge clk) disable iff (!rstN) ctrlReg[21] && (ctrlReg[27] == nmfiStrap)); // R10
  AST_RET_ADDR: assert property (@(posedge clk) disable iff (!rstN) (retAddr + AW'(4)) == lrFiq); // R11
endmodule

bind intr_entry_ctrl intr_entry_chk #(.AW(AW)) chk_i (.*);

// File: tb/intr_entry_ctrl_tb.sv
module intr_entry_ctrl_tb_top;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          irqLineN = 1'b1, fiqLineN = 1'b1, nmfiStrap = 1'b0;
  logic          swWrEn = 1'b0, swWrI = 1'b0, swWrF = 1'b0, fiqRet = 1'b0;
  logic [AW-1:0] lrFiq = '0;
  logic          takeIrq, takeFiq, maskI, maskF, fiqActive;
  logic [AW-1:0] retAddr;
  logic [31:0]   ctrlReg;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // reference model state
  bit mReqI, mReqF, mI, mF, mFa, mTI, mTF;

  always #2 clk = ~clk;  // 250 MHz

  intr_entry_ctrl #(.AW(AW)) dut_i (.*);

  task automatic chk(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit [31:0] expCtrl;
    expCtrl = 32'h0020_0000 | (32'(nmfiStrap) << 27);
    if (!rstN) begin
      chk("R1 maskI in reset", maskI, 1);
      chk("R1 maskF in reset", maskF, 1);
      chk("R1 fiqActive in reset", fiqActive, 0);
      chk("R1 take strobes in reset", {takeIrq, takeFiq}, 0);
    end else begin
      chk("R2 R3 R4 takeIrq", takeIrq, mTI);
      chk("R2 R3 R5 takeFiq", takeFiq, mTF);
      chk("R4 R7 R9 maskI", maskI, mI);
      chk(nmfiStrap ? "R8 R9 maskF" : "R7 R9 maskF", maskF, mF);
      chk("R5 R6 fiqActive", fiqActive, mFa);
    end
    chk("R10 ctrlReg", ctrlReg, expCtrl);
    chk("R11 retAddr", retAddr, AW'(lrFiq - AW'(4)));
  endtask

  // advance the model across the coming rising edge with the inputs now applied
  task automatic modelStep();
    bit wF, wI;
    if (!rstN) begin
      mReqI = 0; mReqF = 0; mI = 1; mF = 1; mFa = 0; mTI = 0; mTF = 0;
      return;
    end
    wF = mReqF && !mF && !mFa;
    wI = mReqI && !mI && !mFa && !wF;
    if (wF) begin
      mI = 1; mF = 1; mFa = 1;
    end else begin
      if (wI) mI = 1;
      else if (swWrEn) begin
        mI = swWrI;
        if (nmfiStrap) mF = swWrF ? mF : 1'b0;
        else           mF = swWrF;
      end
      if (fiqRet) mFa = 0;
    end
    mTI = wI; mTF = wF;
    mReqI = !irqLineN; mReqF = !fiqLineN;
  endtask

  task automatic runPhase(input bit strap, input int cycles);
    int holdI = 0, holdF = 0;
    // strap changes only under reset
    @(negedge clk); compareAll();
    rstN = 0; nmfiStrap = strap; modelStep();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); compareAll(); modelStep();
    end
    @(negedge clk); compareAll(); rstN = 1; modelStep();
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      compareAll();
      if (holdI == 0) begin irqLineN = ($urandom_range(0, 9) < 5); holdI = $urandom_range(1, 6); end
      else holdI--;
      if (holdF == 0) begin fiqLineN = ($urandom_range(0, 9) < 6); holdF = $urandom_range(1, 6); end
      else holdF--;
      swWrEn = ($urandom_range(0, 9) < 3);
      swWrI  = $urandom_range(0, 1);
      swWrF  = $urandom_range(0, 1);
      fiqRet = ($urandom_range(0, 9) < 1);
      lrFiq  = ($urandom_range(0, 3) == 0) ? AW'($urandom_range(0, 5)) : AW'($urandom);
      modelStep();
    end
  endtask

  initial begin
    modelStep();
    runPhase(1'b0, 3000);
    runPhase(1'b1, 3000);
    runPhase(1'b0, 1000);
    runPhase(1'b1, 1000);
    @(negedge clk); compareAll();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int w = 0; w < 150000; w++) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule